// File: doc/BRIEF.md
# CCD Readout Clock Sequencer

This block is the digital timing generator for a three-phase, full-frame CCD. A start pulse begins a frame. First comes an integration interval, during which every vertical phase stays low. Then the block runs one line at a time. For each line it moves one or two rows into the serial register with the vertical phases and the transfer gate. It then clocks the serial register out with the horizontal phases. During that readout it issues a reset pulse to the sense node and two sample strobes per output pixel, so an external converter can do correlated double sampling. Every line starts with a fixed number of dark prescan pixels, and a dark flag marks them.

At start, the block captures the binning mode, the port geometry, the integration length and the transfer-gate option, and it holds them for the whole frame. Vertical binning combines two rows in the serial register by issuing two row transfers per line. Horizontal binning doubles the pixel period and keeps the summing gate high, so two serial cells merge before the charge reaches the sense node. The port geometry sets how many lines and pixels each output reads. All outputs are logic-level signals. The analog level shifting, the converter and the shutter live elsewhere.

Top module: `ccd_clk_seq`

## Requirements
- R1: After reset, with no frame running, every phase output, strobe and flag is low.
- R2: A start pulse sampled while idle begins integration. Integration lasts max(intLen,1) clocks, and during it the vertical phases, the transfer gate and frameValid are all low.
- R3: A row transfer is three consecutive clocks with exactly one of V1, V2, V3 high, in that order. A line uses two row transfers when binMode is 1 or 2, and one otherwise.
- R4: When vtgMirror is 1, the transfer gate equals V3. When it is 0, the transfer gate is high only on the V3 clock of the last row transfer of each line.
- R5: While lineValid is high, exactly one of H1, H2, H3 is high. The pattern starts at H1 on each line and rotates H1→H2→H3→H1 every clock. All three are low outside line readout.
- R6: A pixel period is SUBSTEPS clocks, or 2*SUBSTEPS when binMode is 2. Within it the reset pulse comes on sub-step 0, sampRef on sub-step 1, and sampSig on the last sub-step.
- R7: With binMode 2, the summing gate is high during readout except for a single low clock on the sub-step just before sampSig. With any other binMode, it equals H1.
- R8: The first PRESCAN pixels of every line have the dark flag high for their full period. The flag is low for all other pixels.
- R9: portMode 1 or 2 halves the line count. portMode 2 also halves the active pixels per line. Vertical binning halves the lines, and binMode 2 halves the active pixels again. portMode 0 or 3 reads the full array.
- R10: frameValid is high from the first row transfer to the last pixel. lineValid is high exactly during the horizontal readout of each line.
- R11: done is high for one clock, on the final sub-step of the last pixel of the frame. The block is idle on the following clock.
- R12: A start pulse that arrives while a frame is running is ignored, including one that arrives in the same clock as done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Frame start request |
| intLen | input | INT_W | Integration length in clocks |
| binMode | input | 2 | 0 none, 1 two rows combined, 2 two rows by two pixels |
| portMode | input | 2 | 0 single, 1 dual (half lines), 2 quad (half lines, half pixels) |
| vtgMirror | input | 1 | Transfer gate copies V3 |
| v1 | output | 1 | Vertical phase 1 |
| v2 | output | 1 | Vertical phase 2 |
| v3 | output | 1 | Vertical phase 3 |
| vtg | output | 1 | Vertical transfer gate |
| h1 | output | 1 | Horizontal phase 1 |
| h2 | output | 1 | Horizontal phase 2 |
| h3 | output | 1 | Horizontal phase 3 |
| sg | output | 1 | Summing gate |
| rstGate | output | 1 | Sense-node reset pulse |
| sampRef | output | 1 | Reset-level sample strobe |
| sampSig | output | 1 | Signal-level sample strobe |
| lineValid | output | 1 | Line readout in progress |
| frameValid | output | 1 | Frame transfer in progress |
| dark | output | 1 | Prescan (dark reference) pixel |
| done | output | 1 | Frame complete, one clock |

## Verification
Two events can fall in the same clock: the done pulse of a finishing frame and a fresh start request. On the very clock where done is seen high, the bench raises start. It then judges the outcome at the ports: frameValid must stay low for the following clocks and no second done may appear. A second start pulse is also placed at a random point inside each frame. The frame length, the per-frame strobe counts and the phase counts must then match the values for a single frame.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_INTEG, ST_VXFER, ST_HREAD} seqState_t;

  typedef struct packed {
    logic       vxfer;
    logic [1:0] vStep;
    logic       vLastRow;
    logic       mirror;
    logic       hread;
    logic       hbin;
    logic       sgDump;
  } ctlStrobes_t;
endpackage

// File: rtl/ccdseq_ctrl.sv
module ccdseq_ctrl
  import ccdseq_pkg::*;
#(
  parameter int ROWS     = 2048,
  parameter int COLS     = 2048,
  parameter int PRESCAN  = 16,
  parameter int SUBSTEPS = 4,
  parameter int INT_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [INT_W-1:0] intLen,
  input  logic [1:0]       binMode,
  input  logic [1:0]       portMode,
  input  logic             vtgMirror,
  output ctlStrobes_t      ctl,
  output logic             rstGate,
  output logic             sampRef,
  output logic             sampSig,
  output logic             dark,
  output logic             lineValid,
  output logic             frameValid,
  output logic             done
);
  localparam int PIX_W  = $clog2(PRESCAN + COLS + 1);
  localparam int LINE_W = $clog2(ROWS + 1);
  localparam int SUB_W  = $clog2(2 * SUBSTEPS + 1);

  seqState_t        st;
  logic [INT_W-1:0] intCnt, intLenQ;
  logic             vbinQ, hbinQ, mirrorQ;
  logic [1:0]       portQ;
  logic [1:0]       rowSub;
  logic             rowCnt;
  logic [SUB_W-1:0] sub;
  logic [PIX_W-1:0] pix;
  logic [LINE_W-1:0] line;

  int               baseRows, baseCols;
  logic [LINE_W-1:0] linesTot;
  logic [PIX_W-1:0]  pixTot;
  logic [SUB_W-1:0]  period;
  logic lastSub, lastPix, lastLine, lastRow, hread, integDone;

  always_comb begin
    baseRows  = (portQ == 2'd1 || portQ == 2'd2) ? ROWS / 2 : ROWS;
    baseCols  = (portQ == 2'd2) ? COLS / 2 : COLS;
    linesTot  = LINE_W'(baseRows >> vbinQ);
    pixTot    = PIX_W'(PRESCAN + (baseCols >> hbinQ));
    period    = hbinQ ? SUB_W'(2 * SUBSTEPS) : SUB_W'(SUBSTEPS);
    hread     = (st == ST_HREAD);
    lastSub   = (sub == period - SUB_W'(1));
    lastPix   = (pix == pixTot - PIX_W'(1));
    lastLine  = (line == linesTot - LINE_W'(1));
    lastRow   = (rowCnt == vbinQ);
    integDone = (intLenQ == '0) || (intCnt + INT_W'(1) >= intLenQ);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= ST_IDLE; intCnt <= '0; intLenQ <= '0;
      vbinQ <= 1'b0; hbinQ <= 1'b0; mirrorQ <= 1'b0; portQ <= '0;
      rowSub <= '0; rowCnt <= 1'b0; sub <= '0; pix <= '0; line <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (start) begin
          st      <= ST_INTEG;
          intCnt  <= '0;
          intLenQ <= intLen;
          vbinQ   <= (binMode == 2'd1) || (binMode == 2'd2);
          hbinQ   <= (binMode == 2'd2);
          portQ   <= portMode;
          mirrorQ <= vtgMirror;
        end
        ST_INTEG: begin
          if (integDone) begin
            st <= ST_VXFER; rowSub <= '0; rowCnt <= 1'b0; line <= '0;
          end else intCnt <= intCnt + INT_W'(1);
        end
        ST_VXFER: begin
          if (rowSub == 2'd2) begin
            rowSub <= '0;
            if (lastRow) begin
              st <= ST_HREAD; sub <= '0; pix <= '0;
            end else rowCnt <= 1'b1;
          end else rowSub <= rowSub + 2'd1;
        end
        ST_HREAD: begin
          if (lastSub) begin
            sub <= '0;
            if (lastPix) begin
              if (lastLine) st <= ST_IDLE;
              else begin
                st <= ST_VXFER; line <= line + LINE_W'(1);
                rowSub <= '0; rowCnt <= 1'b0;
              end
            end else pix <= pix + PIX_W'(1);
          end else sub <= sub + SUB_W'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.vxfer    = (st == ST_VXFER);
    ctl.vStep    = rowSub;
    ctl.vLastRow = lastRow;
    ctl.mirror   = mirrorQ;
    ctl.hread    = hread;
    ctl.hbin     = hbinQ;
    ctl.sgDump   = hread && hbinQ && (sub == period - SUB_W'(2));
    rstGate      = hread && (sub == '0);
    sampRef      = hread && (sub == SUB_W'(1));
    sampSig      = hread && lastSub;
    dark         = hread && (pix < PIX_W'(PRESCAN));
    lineValid    = hread;
    frameValid   = hread || (st == ST_VXFER);
    done         = hread && lastSub && lastPix && lastLine;
  end

  // R11
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (st == ST_IDLE) && !done);
  // R12
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st == ST_VXFER || st == ST_HREAD) |=> (st != ST_INTEG));
  // R6
  reset_before_ref_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstGate |=> sampRef);
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sampRef && sampSig) && !(rstGate && sampSig));
endmodule

// File: rtl/ccdseq_phases.sv
module ccdseq_phases
  import ccdseq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t ctl,
  output logic        v1,
  output logic        v2,
  output logic        v3,
  output logic        vtg,
  output logic        h1,
  output logic        h2,
  output logic        h3,
  output logic        sg
);
  logic [1:0] hIdx;
  logic [2:0] hVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) hIdx <= '0;
    else if (ctl.hread) hIdx <= (hIdx == 2'd2) ? 2'd0 : hIdx + 2'd1;
    else hIdx <= '0;
  end

  always_comb begin
    v1   = ctl.vxfer && (ctl.vStep == 2'd0);
    v2   = ctl.vxfer && (ctl.vStep == 2'd1);
    v3   = ctl.vxfer && (ctl.vStep == 2'd2);
    vtg  = ctl.mirror ? v3 : (v3 && ctl.vLastRow);
    hVec = ctl.hread ? (3'b001 << hIdx) : 3'b000;
    h1   = hVec[0];
    h2   = hVec[1];
    h3   = hVec[2];
    sg   = ctl.hread && (ctl.hbin ? !ctl.sgDump : h1);
  end

  // R3
  v_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    (v1 |=> v2) and (v2 |=> v3));
  // R5
  h_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hread |-> $onehot({h3, h2, h1}));
  // R5
  h_rotate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.hread && $past(ctl.hread)) |->
      ({h3, h2, h1} == {$past(h2), $past(h1), $past(h3)}));
  // R2
  v_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.vxfer |-> !(v1 || v2 || v3 || vtg));
endmodule

// File: rtl/ccd_clk_seq.sv
module ccd_clk_seq
  import ccdseq_pkg::*;
#(
  parameter int ROWS     = 2048,
  parameter int COLS     = 2048,
  parameter int PRESCAN  = 16,
  parameter int SUBSTEPS = 4,
  parameter int INT_W    = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [INT_W-1:0] intLen,
  input  logic [1:0]       binMode,
  input  logic [1:0]       portMode,
  input  logic             vtgMirror,
  output logic             v1,
  output logic             v2,
  output logic             v3,
  output logic             vtg,
  output logic             h1,
  output logic             h2,
  output logic             h3,
  output logic             sg,
  output logic             rstGate,
  output logic             sampRef,
  output logic             sampSig,
  output logic             lineValid,
  output logic             frameValid,
  output logic             dark,
  output logic             done
);
  ctlStrobes_t ctl;

  ccdseq_ctrl #(.ROWS(ROWS), .COLS(COLS), .PRESCAN(PRESCAN),
                .SUBSTEPS(SUBSTEPS), .INT_W(INT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .intLen(intLen),
    .binMode(binMode), .portMode(portMode), .vtgMirror(vtgMirror),
    .ctl(ctl), .rstGate(rstGate), .sampRef(sampRef), .sampSig(sampSig),
    .dark(dark), .lineValid(lineValid), .frameValid(frameValid), .done(done)
  );

  ccdseq_phases u_phases (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .v1(v1), .v2(v2), .v3(v3), .vtg(vtg),
    .h1(h1), .h2(h2), .h3(h3), .sg(sg)
  );
endmodule

// File: tb/ccd_clk_seq_bench.sv
module ccd_clk_seq_bench;
  localparam int ROWS = 4, COLS = 8, PRESCAN = 2, SUBSTEPS = 4, INT_W = 16;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, vtgMirror = 1'b0;
  logic [INT_W-1:0] intLen = '0;
  logic [1:0] binMode = '0, portMode = '0;
  logic v1, v2, v3, vtg, h1, h2, h3, sg, rstGate, sampRef, sampSig;
  logic lineValid, frameValid, dark, done;

  int tests = 0, fails = 0;

  ccd_clk_seq #(.ROWS(ROWS), .COLS(COLS), .PRESCAN(PRESCAN),
                .SUBSTEPS(SUBSTEPS), .INT_W(INT_W)) u_ccd_clk_seq (
    .clk(clk), .rstN(rstN), .start(start), .intLen(intLen),
    .binMode(binMode), .portMode(portMode), .vtgMirror(vtgMirror),
    .v1(v1), .v2(v2), .v3(v3), .vtg(vtg), .h1(h1), .h2(h2), .h3(h3),
    .sg(sg), .rstGate(rstGate), .sampRef(sampRef), .sampSig(sampSig),
    .lineValid(lineValid), .frameValid(frameValid), .dark(dark), .done(done)
  );

  always #4 clk = ~clk;

  // monitor counters, sampled on the falling edge
  int cFv, cLv, cDark, cSig, cRef, cRst, cV1, cV2, cV3, cVtg, cH1, cSg, cDone;
  int badOrder, badRot, badQuiet, badSg, badMirror;
  logic seenRst, seenRef, prevSg, prevLv, curHbin, curMirror;
  logic [2:0] prevH;

  task automatic clearMon();
    cFv = 0; cLv = 0; cDark = 0; cSig = 0; cRef = 0; cRst = 0;
    cV1 = 0; cV2 = 0; cV3 = 0; cVtg = 0; cH1 = 0; cSg = 0; cDone = 0;
    badOrder = 0; badRot = 0; badQuiet = 0; badSg = 0; badMirror = 0;
    seenRst = 0; seenRef = 0; prevSg = 0; prevLv = 0; prevH = 3'b000;
  endtask

  always @(negedge clk) if (rstN) begin
    cFv += int'(frameValid); cLv += int'(lineValid); cDark += int'(dark);
    cSig += int'(sampSig); cRef += int'(sampRef); cRst += int'(rstGate);
    cV1 += int'(v1); cV2 += int'(v2); cV3 += int'(v3); cVtg += int'(vtg);
    cH1 += int'(h1); cSg += int'(sg); cDone += int'(done);
    if (!frameValid && (v1 || v2 || v3 || vtg)) badQuiet++;
    if (!lineValid && (h1 || h2 || h3 || sg)) badQuiet++;
    if (curMirror && (vtg != v3)) badMirror++;
    if (lineValid) begin
      if ($countones({h3, h2, h1}) != 1) badRot++;
      else if (!prevLv && !h1) badRot++;
      else if (prevLv && ({h3, h2, h1} != {prevH[1], prevH[0], prevH[2]})) badRot++;
      if (!curHbin && (sg != h1)) badSg++;
      if (curHbin && sampSig && prevSg) badSg++;
    end
    if (rstGate) begin seenRst = 1; seenRef = 0; end
    if (sampRef) begin if (!seenRst) badOrder++; seenRef = 1; end
    if (sampSig) begin if (!seenRef) badOrder++; seenRst = 0; seenRef = 0; end
    prevH = {h3, h2, h1}; prevLv = lineValid; prevSg = sg;
  end

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int fLines(input int pm, input int bm);
    int r = (pm == 1 || pm == 2) ? ROWS / 2 : ROWS;
    return (bm == 1 || bm == 2) ? r / 2 : r;
  endfunction
  function automatic int fAct(input int pm, input int bm);
    int c = (pm == 2) ? COLS / 2 : COLS;
    return (bm == 2) ? c / 2 : c;
  endfunction

  task automatic runFrame(input int bm, input int pm, input int il,
                          input bit mir, input int midAt);
    int lines = fLines(pm, bm);
    int rpl = (bm == 1 || bm == 2) ? 2 : 1;
    int per = (bm == 2) ? 2 * SUBSTEPS : SUBSTEPS;
    int ppl = PRESCAN + fAct(pm, bm);
    int lineCyc = ppl * per;
    int expTotal = ((il < 1) ? 1 : il) + lines * (3 * rpl + lineCyc);
    int n = 0, fvHold;
    string tag;
    tag = $sformatf("bm%0d pm%0d il%0d mir%0d", bm, pm, il, mir);
    clearMon();
    curHbin = (bm == 2); curMirror = mir;
    @(negedge clk);
    binMode = 2'(bm); portMode = 2'(pm); intLen = INT_W'(il);
    vtgMirror = mir; start = 1'b1;
    @(negedge clk);
    n = 1; start = 1'b0;
    // R2: integration quiet before the first row transfer
    if (il > 1) check({"R2 integ quiet ", tag}, int'(frameValid || v1 || vtg), 0);
    while (!done && n < 50000) begin
      @(negedge clk);
      n++;
      start = (n == midAt);  // R12: mid-frame start must be ignored
    end
    // R12: start coincident with done
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    fvHold = cFv;
    repeat (10) @(negedge clk);
    check({"R11 done cycle ", tag}, n, expTotal);
    check({"R11 done count ", tag}, cDone, 1);
    check({"R12 no restart ", tag}, cFv - fvHold, 0);
    check({"R10 frameValid ", tag}, cFv, lines * (3 * rpl + lineCyc));
    check({"R10 lineValid ", tag}, cLv, lines * lineCyc);
    check({"R8 dark cycles ", tag}, cDark, lines * PRESCAN * per);
    check({"R9 sig strobes ", tag}, cSig, lines * ppl);
    check({"R6 ref strobes ", tag}, cRef, lines * ppl);
    check({"R6 reset pulses ", tag}, cRst, lines * ppl);
    check({"R6 strobe order ", tag}, badOrder, 0);
    check({"R3 v1 count ", tag}, cV1, lines * rpl);
    check({"R3 v3 count ", tag}, cV3, lines * rpl);
    check({"R4 vtg count ", tag}, cVtg, mir ? lines * rpl : lines);
    check({"R4 vtg mirror ", tag}, badMirror, 0);
    check({"R5 rotation ", tag}, badRot, 0);
    check({"R5 h1 count ", tag}, cH1, lines * ((lineCyc + 2) / 3));
    check({"R2 quiet outside ", tag}, badQuiet, 0);
    check({"R7 sg shape ", tag}, badSg, 0);
    check({"R7 sg count ", tag}, cSg,
          (bm == 2) ? lines * (lineCyc - ppl) : lines * ((lineCyc + 2) / 3));
  endtask

  initial begin
    void'($urandom(32'd2718));
    clearMon();
    curHbin = 0; curMirror = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset outputs",
          int'({v1, v2, v3, vtg, h1, h2, h3, sg, rstGate, sampRef, sampSig,
                lineValid, frameValid, dark, done}), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle outputs",
          int'({v1, v2, v3, vtg, h1, h2, h3, sg, rstGate, sampRef, sampSig,
                lineValid, frameValid, dark, done}), 0);
    // directed corners: every geometry and binning, both gate options
    for (int pm = 0; pm < 4; pm++)
      for (int bm = 0; bm < 4; bm++)
        runFrame(bm, pm, (pm + bm) % 3, bit'(bm[0] ^ pm[0]), 7);
    // random mix
    for (int i = 0; i < 20; i++)
      runFrame(int'($urandom_range(3, 0)), int'($urandom_range(3, 0)),
               int'($urandom_range(25, 0)), bit'($urandom_range(1, 0)),
               int'($urandom_range(150, 2)));
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule